// File: doc/BRIEF.md
# Audio Channel Sample Sequencer

This block drives a single audio channel. It takes 16-bit words and plays each one as two 8-bit samples: the high byte goes out first, then the low byte. Each sample is held for a programmable number of clock cycles. An eight-encoding state machine controls the sequence. Words can arrive in two ways:

- **Processor mode:** a register write supplies the word, and the machine enters its playback loop at once.
- **DMA mode:** the block raises fetch requests to an external fetch engine. It drops the first returned word, because that word belongs to the fetcher's pipeline, and starts playback with the second.

In DMA mode a length counter counts the words that are used. When the waveform is about to end, the block asks the fetcher to rewind to the start of the table. The interrupt line is raised once per word in processor mode, and once per waveform pass in DMA mode. Two attach controls decide which byte boundary issues the next fetch request. If no new word arrives in time, the buffered word is played again.

Top module: `aud_seq_top`

## Requirements
- R1: After synchronous reset, `seq_state` is 000, `irq`, `fetch_req`, `fetch_restart` and `sample_act` are 0, and `sample_out` is 0.
- R2: The state encodings are:
  - idle = 000
  - DMA priming = 001
  - high-byte playback = 010
  - low-byte playback = 011
  - DMA second-word wait = 101

  The encodings 100, 110 and 111 fall back to idle.
- R3: In idle with `dma_en` low, a `dat_wr` pulse loads `dat_val` and moves to 010 on the next clock edge. If `dma_en` and `dat_wr` are high together in idle, `dma_en` wins and the next state is 001.
- R4: State 010 drives `dat` bits [15:8] on `sample_out`, and state 011 drives bits [7:0]. Each state lasts max(P,1) cycles, where P is the last value written through `per_wr`. When it ends, control passes from 010 to 011, or from 011 onward.
- R5: In processor mode, `irq` is set on every entry to 010. A `dat_wr` during playback fills the buffer. At the end of 011, one of two things happens:
  - If `irq` is still set, the machine goes to idle.
  - Otherwise it goes to 010 with the buffered word.
- R6: In DMA mode, enabling from idle enters 001 and raises a request. The first returned word is discarded; the machine enters 101 and raises a request. The next returned word starts 010 playback, and a request is raised again.
- R7: A raised `fetch_req` stays high until a `fetch_grant` cycle. A pending `fetch_restart` also clears on that same grant. Returning to idle drops both.
- R8: The length counter is loaded with L on DMA start. It counts down once per used word. A word that arrives while the count is at most 1 does three things:
  - it sets `fetch_restart`;
  - it reloads the count to L;
  - it sets `irq` at the moment that word starts playback.
- R9: In DMA mode, the request point depends on the attach controls:

  | `attach_per` | `attach_vol` | Request raised on |
  |---|---|---|
  | 0 | any | 011→010 |
  | 1 | 0 | 010→011 only |
  | 1 | 1 | both transitions |

- R10: If no new word has arrived by the end of 011, the same buffered word is played again. A repeated end-of-waveform word does not raise `irq` a second time.
- R11: Clearing `dma_en` during playback ends the loop at the end of 011, and the machine goes to idle. Clearing it in 001 or 101 goes to idle at once.
- R12: `irq_clr` clears `irq`. If `irq` is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Selects DMA supply; clearing it stops playback |
| attach_vol | input | 1 | Attach control: request at the word boundary |
| attach_per | input | 1 | Attach control: request at the mid-word boundary |
| per_wr | input | 1 | Write strobe for the sample period |
| per_val | input | PER_W | Sample period in cycles |
| len_wr | input | 1 | Write strobe for the waveform length |
| len_val | input | LEN_W | Waveform length in words |
| dat_wr | input | 1 | Processor data write strobe |
| dat_val | input | 16 | Processor data word |
| irq_clr | input | 1 | Clears the interrupt request |
| fetch_grant | input | 1 | Once-per-line acceptance of a pending request |
| fetch_valid | input | 1 | Returned word valid pulse |
| fetch_data | input | 16 | Returned word |
| fetch_req | output | 1 | Pending word request |
| fetch_restart | output | 1 | Pending rewind-to-start request |
| sample_out | output | 8 | Current 8-bit sample |
| sample_act | output | 1 | High in states 010 and 011 |
| irq | output | 1 | Interrupt request |
| seq_state | output | 3 | State machine encoding |

## Verification
The bench builds the block with an 8-bit period field and a 4-bit length field.

- **Period:** the 8-bit field makes the largest period, 255 cycles per sample, cheap to play through. A period of 0 exercises the one-cycle minimum.
- **Length:** a three-word waveform wraps within a few words of fetch traffic. The bench can therefore observe the rewind request, the end-of-waveform interrupt and the word-repeat case in one DMA run.
- **Fetch model:** each request is served by a grant followed by a 14-cycle return latency. This is kept short against a 40-cycle period, so every attach-timing check lands inside a single byte phase.

// File: rtl/aud_seq_pkg.sv
package aud_seq_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'b000,
        SQ_PRIME = 3'b001,
        SQ_HI    = 3'b010,
        SQ_LO    = 3'b011,
        SQ_FILL  = 3'b101
    } sq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              last;
    } sq_word_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                    input logic upper);
        return upper ? w[WORD_W-1 -: BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/aud_seq_period.sv
module aud_seq_period #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] per,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= (per > W'(1)) ? per : W'(1);
        else if (cnt > W'(1))
            cnt <= cnt - W'(1);
    end

    assign expire = (cnt <= W'(1));
endmodule

// File: rtl/aud_seq_length.sv
module aud_seq_length #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         word_in,
    input  logic [W-1:0] len,
    output logic         wrap
);
    logic [W-1:0] cnt;

    assign wrap = word_in && (cnt <= W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= len;
        else if (word_in)
            cnt <= wrap ? len : cnt - W'(1);
    end
endmodule

// File: rtl/aud_seq_reqtrk.sv
module aud_seq_reqtrk (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic raise_rw,
    input  logic grant,
    input  logic drop,
    output logic req,
    output logic rw_pend
);
    logic taken;
    assign taken = grant && req;

    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= 1'b0;
            rw_pend <= 1'b0;
        end else begin
            if (raise)
                req <= 1'b1;
            else if (taken || drop)
                req <= 1'b0;
            if (raise_rw)
                rw_pend <= 1'b1;
            else if (taken || drop)
                rw_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/aud_seq_top.sv
module aud_seq_top
    import aud_seq_pkg::*;
#(
    parameter int PER_W = 16,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              attach_vol,
    input  logic              attach_per,
    input  logic              per_wr,
    input  logic [PER_W-1:0]  per_val,
    input  logic              len_wr,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              dat_wr,
    input  logic [WORD_W-1:0] dat_val,
    input  logic              irq_clr,
    input  logic              fetch_grant,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_data,
    output logic              fetch_req,
    output logic              fetch_restart,
    output logic [BYTE_W-1:0] sample_out,
    output logic              sample_act,
    output logic              irq,
    output logic [2:0]        seq_state
);
    sq_state_e         st, st_nx;
    logic              mode_dma;
    logic [WORD_W-1:0] cur;
    sq_word_t          hold;
    logic [PER_W-1:0]  per_reg;
    logic [LEN_W-1:0]  len_reg;

    logic loop_st, per_exp, per_load;
    logic hi_end, lo_end, lo_quit, lo_next;
    logic cpu_start, word_use, wrap, irq_set;
    logic req_raise, req_drop;

    assign loop_st   = (st == SQ_HI) || (st == SQ_LO);
    assign hi_end    = (st == SQ_HI) && per_exp;
    assign lo_end    = (st == SQ_LO) && per_exp;
    assign lo_quit   = lo_end && (mode_dma ? !dma_en : irq);
    assign lo_next   = lo_end && !lo_quit;
    assign cpu_start = (st == SQ_IDLE) && !dma_en && dat_wr;
    assign word_use  = fetch_valid && dma_en &&
                       ((st == SQ_FILL) || (mode_dma && loop_st));

    // next-state selection
    always_comb begin
        st_nx = st;
        case (st)
            SQ_IDLE:  if (dma_en) st_nx = SQ_PRIME;
                      else if (dat_wr) st_nx = SQ_HI;
            SQ_PRIME: if (!dma_en) st_nx = SQ_IDLE;
                      else if (fetch_valid) st_nx = SQ_FILL;
            SQ_FILL:  if (!dma_en) st_nx = SQ_IDLE;
                      else if (fetch_valid) st_nx = SQ_HI;
            SQ_HI:    if (per_exp) st_nx = SQ_LO;
            SQ_LO:    if (per_exp) st_nx = lo_quit ? SQ_IDLE : SQ_HI;
            default:  st_nx = SQ_IDLE;
        endcase
    end

    assign per_load = (st_nx != st) && ((st_nx == SQ_HI) || (st_nx == SQ_LO));

    assign req_raise = ((st == SQ_IDLE) && dma_en) ||
                       (((st == SQ_PRIME) || (st == SQ_FILL)) && dma_en && fetch_valid) ||
                       (mode_dma && hi_end && attach_per) ||
                       (mode_dma && lo_next && (attach_vol || !attach_per));
    assign req_drop  = (st != SQ_IDLE) && (st_nx == SQ_IDLE);

    assign irq_set = cpu_start ||
                     (!mode_dma && lo_next) ||
                     ((st == SQ_FILL) && word_use && wrap) ||
                     (mode_dma && lo_next && hold.last);

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_IDLE;
        else     st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_dma <= 1'b0;
            cur      <= '0;
            hold     <= '0;
            per_reg  <= '0;
            len_reg  <= '0;
            irq      <= 1'b0;
        end else begin
            if (per_wr) per_reg <= per_val;
            if (len_wr) len_reg <= len_val;
            if (st == SQ_IDLE) mode_dma <= dma_en;

            if (irq_set)      irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;

            if (cpu_start)
                cur <= dat_val;
            else if ((st == SQ_FILL) && word_use)
                cur <= fetch_data;
            else if (lo_next)
                cur <= hold.word;

            if (!mode_dma && loop_st && dat_wr)
                hold <= '{word: dat_val, last: 1'b0};
            else if (word_use && loop_st)
                hold <= '{word: fetch_data, last: wrap};
            else if (lo_next)
                hold.last <= 1'b0;
        end
    end

    aud_seq_period #(.W(PER_W)) u_period (
        .clk    (clk),
        .rst    (rst),
        .load   (per_load),
        .per    (per_reg),
        .expire (per_exp)
    );

    aud_seq_length #(.W(LEN_W)) u_length (
        .clk     (clk),
        .rst     (rst),
        .start   ((st == SQ_IDLE) && dma_en),
        .word_in (word_use),
        .len     (len_reg),
        .wrap    (wrap)
    );

    aud_seq_reqtrk u_req (
        .clk      (clk),
        .rst      (rst),
        .raise    (req_raise),
        .raise_rw (wrap),
        .grant    (fetch_grant),
        .drop     (req_drop),
        .req      (fetch_req),
        .rw_pend  (fetch_restart)
    );

    assign sample_act = loop_st;
    assign sample_out = loop_st ? pick_byte(cur, st == SQ_HI) : '0;
    assign seq_state  = st;
endmodule

// File: rtl/aud_seq_chk.sv
module aud_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       dma_en,
    input logic       dat_wr,
    input logic       fetch_valid,
    input logic       fetch_req,
    input logic [7:0] sample_out,
    input logic [2:0] seq_state
);
    // R2: only the five used encodings ever appear
    a_r2_legal_state: assert property (@(posedge clk) disable iff (rst)
        seq_state inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b101});

    a_r3_write_starts: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'b000 && !dma_en && dat_wr) |=> seq_state == 3'b010);

    a_r6_dma_entry: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'b000 && dma_en) |=> (seq_state == 3'b001 && fetch_req));

    a_r6_discard_first: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'b001 && dma_en && fetch_valid) |=> seq_state == 3'b101);

    a_r4_upper_then_lower: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'b010) |=> (seq_state == 3'b011 ||
                                   (seq_state == 3'b010 && $stable(sample_out))));

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'b000) |-> (sample_out == 8'h00));
endmodule

bind aud_seq_top aud_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dma_en      (dma_en),
    .dat_wr      (dat_wr),
    .fetch_valid (fetch_valid),
    .fetch_req   (fetch_req),
    .sample_out  (sample_out),
    .seq_state   (seq_state)
);

// File: tb/aud_seq_top_test.sv
`timescale 1ns/100ps
module aud_seq_top_test;
    localparam int PER_W = 8;
    localparam int LEN_W = 4;
    localparam int NVEC  = 5;

    // {period, word, expected upper byte, expected lower byte}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'd1,   16'hA55A, 8'hA5, 8'h5A},
        {8'd0,   16'h1234, 8'h12, 8'h34},
        {8'd3,   16'hFF00, 8'hFF, 8'h00},
        {8'd7,   16'h807F, 8'h80, 8'h7F},
        {8'd255, 16'h0102, 8'h01, 8'h02}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dma_en = 0, attach_vol = 0, attach_per = 0;
    logic per_wr = 0, len_wr = 0, dat_wr = 0, irq_clr = 0;
    logic [PER_W-1:0] per_val = '0;
    logic [LEN_W-1:0] len_val = '0;
    logic [15:0] dat_val = '0, fetch_data = '0;
    logic fetch_grant = 0, fetch_valid = 0;
    logic fetch_req, fetch_restart, sample_act, irq;
    logic [7:0] sample_out;
    logic [2:0] seq_state;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    aud_seq_top #(.PER_W(PER_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .dma_en(dma_en), .attach_vol(attach_vol),
        .attach_per(attach_per), .per_wr(per_wr), .per_val(per_val),
        .len_wr(len_wr), .len_val(len_val), .dat_wr(dat_wr), .dat_val(dat_val),
        .irq_clr(irq_clr), .fetch_grant(fetch_grant), .fetch_valid(fetch_valid),
        .fetch_data(fetch_data), .fetch_req(fetch_req), .fetch_restart(fetch_restart),
        .sample_out(sample_out), .sample_act(sample_act), .irq(irq),
        .seq_state(seq_state)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; dma_en = 0; attach_vol = 0; attach_per = 0;
        dat_wr = 0; irq_clr = 0; fetch_grant = 0; fetch_valid = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_regs(input logic [PER_W-1:0] p, input logic [LEN_W-1:0] l);
        per_wr = 1; per_val = p; len_wr = 1; len_val = l;
        @(negedge clk);
        per_wr = 0; len_wr = 0;
    endtask

    task automatic serve(input logic [15:0] w);
        fetch_grant = 1;
        @(negedge clk);
        fetch_grant = 0;
        repeat (13) @(negedge clk);
        fetch_valid = 1; fetch_data = w;
        @(negedge clk);
        fetch_valid = 0;
    endtask

    task automatic wait_for(input logic [2:0] s);
        while (seq_state !== s) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 state", seq_state, 3'b000);
        chk("R1 irq", irq, 0);
        chk("R1 req", {fetch_req, fetch_restart}, 2'b00);
        chk("R1 act", sample_act, 0);
        chk("R1 sample", sample_out, 8'h00);

        // R4 R5: table walk, processor mode, irq left pending so loop ends
        for (int i = 0; i < NVEC; i++) begin
            int pe;
            do_reset();
            set_regs(VEC[i][39:32], 4'd1);
            pe = (VEC[i][39:32] > 1) ? int'(VEC[i][39:32]) : 1;
            dat_wr = 1; dat_val = VEC[i][31:16];
            @(negedge clk);
            dat_wr = 0;
            chk("R3 enter upper", seq_state, 3'b010);
            chk("R5 irq on entry", irq, 1);
            repeat (pe - 1) @(negedge clk);
            chk("R4 upper byte held", {seq_state, sample_out}, {3'b010, VEC[i][15:8]});
            @(negedge clk);
            chk("R4 lower byte", {seq_state, sample_out}, {3'b011, VEC[i][7:0]});
            repeat (pe - 1) @(negedge clk);
            chk("R4 lower held", seq_state, 3'b011);
            @(negedge clk);
            chk("R5 unserviced goes idle", seq_state, 3'b000);
        end

        // R3 priority of dma_en over dat_wr
        do_reset();
        set_regs(8'd4, 4'd2);
        dma_en = 1; dat_wr = 1; dat_val = 16'hDEAD;
        @(negedge clk);
        dat_wr = 0;
        chk("R3 dma priority", seq_state, 3'b001);
        dma_en = 0;
        @(negedge clk);
        chk("R11 leave priming", seq_state, 3'b000);
        chk("R7 drop on idle", fetch_req, 0);

        // R5 R12 serviced processor loop
        do_reset();
        set_regs(8'd6, 4'd1);
        dat_wr = 1; dat_val = 16'h1122;
        @(negedge clk);
        irq_clr = 1; dat_val = 16'h3344;
        @(negedge clk);
        irq_clr = 0; dat_wr = 0;
        chk("R12 irq cleared", irq, 0);
        wait_for(3'b011);
        wait_for(3'b010);
        chk("R5 next word", sample_out, 8'h33);
        chk("R5 irq again", irq, 1);
        irq_clr = 1; dat_wr = 1; dat_val = 16'h5566;
        @(negedge clk);
        irq_clr = 0; dat_wr = 0;
        wait_for(3'b011);
        repeat (5) @(negedge clk);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        chk("R12 set wins", {seq_state, irq}, {3'b010, 1'b1});
        chk("R5 third word", sample_out, 8'h55);

        // R6 R7 R8 R10 R11 DMA run, length 3
        do_reset();
        set_regs(8'd40, 4'd3);
        dma_en = 1;
        @(negedge clk);
        chk("R6 priming", {seq_state, fetch_req}, {3'b001, 1'b1});
        serve(16'hEEEE);
        chk("R6 discard to 101", {seq_state, fetch_req}, {3'b101, 1'b1});
        serve(16'hB0B1);
        chk("R6 play second word", {seq_state, sample_out}, {3'b010, 8'hB0});
        chk("R6 request on entry", fetch_req, 1);
        serve(16'hC0C1);
        chk("R8 no restart yet", {fetch_req, fetch_restart}, 2'b00);
        wait_for(3'b011);
        wait_for(3'b010);
        chk("R6 buffered word", sample_out, 8'hC0);
        chk("R9 request at word boundary", fetch_req, 1);
        chk("R8 irq not yet", irq, 0);
        serve(16'hD0D1);
        chk("R8 restart raised", {fetch_req, fetch_restart}, 2'b01);
        wait_for(3'b011);
        wait_for(3'b010);
        chk("R8 last word irq", {sample_out, irq}, {8'hD0, 1'b1});
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        chk("R7 held pending", {fetch_req, fetch_restart}, 2'b11);
        wait_for(3'b011);
        wait_for(3'b010);
        chk("R10 repeated word", sample_out, 8'hD0);
        chk("R10 no second irq", irq, 0);
        fetch_grant = 1;
        @(negedge clk);
        fetch_grant = 0;
        chk("R7 grant clears", {fetch_req, fetch_restart}, 2'b00);
        dma_en = 0;
        wait_for(3'b011);
        while (seq_state === 3'b011) @(negedge clk);
        chk("R11 stop to idle", seq_state, 3'b000);

        // R9 attach timing
        do_reset();
        set_regs(8'd40, 4'd8);
        attach_per = 1;
        dma_en = 1;
        @(negedge clk);
        serve(16'h0101);
        serve(16'h0202);
        serve(16'h0303);
        wait_for(3'b011);
        chk("R9 period attach mid-word", fetch_req, 1);
        serve(16'h0404);
        wait_for(3'b010);
        chk("R9 period attach no word-boundary", fetch_req, 0);
        attach_vol = 1;
        wait_for(3'b011);
        chk("R9 both mid-word", fetch_req, 1);
        serve(16'h0505);
        wait_for(3'b010);
        chk("R9 both word-boundary", fetch_req, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule